// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the state sequencer that steers the datapath of a multicycle processor executing 16-bit instructions. It holds one of eight control states. In each state it drives the datapath strobes and mux selects: instruction-register load, PC load, instruction-memory read, data-memory read and write, register-file write, write-back source, destination-register select, ALU operand selects, ALU operation, shifter operation, immediate-format select, and a flag-save strobe. The datapath, the register file and both memories sit outside the block.

Each instruction begins with a fetch state and then a decode state. From there the sequencer takes one of four paths. An arithmetic/logic instruction finishes in one execute-and-write-back state, where the instruction's function and shift fields are passed straight to the ALU and shifter. A memory instruction computes its address, then performs either a store or a read that is followed by a register write-back. A branch adds the scaled offset to the PC, and the PC is written only when the branch condition input is high. The outputs are a Moore decode of the state. The only exceptions are the ALU and shifter operation codes in the execute state and the PC strobe in the branch state, which follow their inputs.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While rst_ni is low the sequencer is in the fetch state, and it leaves reset in the fetch state.
- R2: Fetch drives ir_wr_o=1, pc_wr_o=1, imem_rd_o=1, alu_src_a_o=0 (PC), alu_src_b_o=2'b01 (constant 2), alu_ctrl_o=3'b010 (add) and shu_ctrl_o=2'b00 (pass), and is always followed by decode.
- R3: Decode drives every control output to 0 and dispatches on op_class_i: 3'b000 (AL) goes to execute, 3'b001 (load) and 3'b010 (store) go to address, and 3'b011 (branch) goes to branch.
- R4: Execute drives reg_wr_o=1, flag_wr_o=1, mem_to_reg_o=0, reg_dst_o=0, alu_src_a_o=1, alu_src_b_o=2'b00, alu_ctrl_o=func_i and shu_ctrl_o=sh_i.
- R5: Address drives alu_src_a_o=1, alu_src_b_o=2'b10, alu_ctrl_o=3'b010, shu_ctrl_o=2'b00 and imm_sel_o=0. It is followed by the store state for class 3'b010 and by the read state for class 3'b001.
- R6: The store state drives only dmem_wr_o=1. The read state drives only dmem_rd_o=1 and is followed by write-back. Write-back drives reg_wr_o=1, mem_to_reg_o=1 and reg_dst_o=1.
- R7: Branch drives alu_src_a_o=0, alu_src_b_o=2'b11, alu_ctrl_o=3'b010, shu_ctrl_o=2'b00, imm_sel_o=1, and pc_wr_o equal to cond_i.
- R8: Execute, store, write-back and branch each return to fetch on the next clock.
- R9: In decode, an op_class_i value from 3'b100 to 3'b111 returns the sequencer to fetch, and no write strobe is asserted on the way.
- R10: Every control output that is not listed for the current state is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_class_i | input | 3 | Instruction class of the instruction held in IR |
| func_i | input | 3 | ALU function field |
| sh_i | input | 2 | Shifter operation field |
| cond_i | input | 1 | Branch condition from the flags |
| ir_wr_o | output | 1 | Load instruction register |
| pc_wr_o | output | 1 | Load PC |
| imem_rd_o | output | 1 | Instruction-memory read |
| dmem_rd_o | output | 1 | Data-memory read into MDR |
| dmem_wr_o | output | 1 | Data-memory write |
| reg_wr_o | output | 1 | Register-file write |
| mem_to_reg_o | output | 1 | Write-back source: 1 = MDR, 0 = shifter result |
| reg_dst_o | output | 1 | Destination: 1 = rd field, 0 = rt field |
| alu_src_a_o | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_src_b_o | output | 2 | ALU B operand: 00 reg B, 01 constant 2, 10 imm8, 11 scaled imm6 |
| alu_ctrl_o | output | 3 | ALU operation |
| shu_ctrl_o | output | 2 | Shifter operation |
| imm_sel_o | output | 1 | Immediate format: 0 = imm8, 1 = imm6 |
| flag_wr_o | output | 1 | Save ALU flags |

## Verification
Instructions of each class are issued back to back, and the whole output vector is compared in every state of each path. A wrong dispatch, a missing state or an extra state therefore shows up as a mismatch on the next instruction's fetch. AL instructions are sent with two different func/sh pairs, which separates fields that pass through from constants. Branches are sent with the condition both high and low, which shows whether the PC strobe is gated. Undefined class codes at both ends of their range, and a reset applied in the middle of a load, confirm that the sequencer returns to fetch without any write.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;
  localparam int ALU_W = 3;
  localparam int SH_W  = 2;
  localparam int CLS_W = 3;

  localparam logic [ALU_W-1:0] ALU_ADD  = 3'b010;
  localparam logic [SH_W-1:0]  SHU_PASS = 2'b00;

  localparam logic [CLS_W-1:0] CLS_AL  = 3'b000;
  localparam logic [CLS_W-1:0] CLS_LD  = 3'b001;
  localparam logic [CLS_W-1:0] CLS_ST  = 3'b010;
  localparam logic [CLS_W-1:0] CLS_BR  = 3'b011;

  typedef enum logic [2:0] {
    ST_FETCH, ST_DECODE, ST_EXEWB, ST_ADDR,
    ST_SMEM,  ST_RMEM,   ST_WB,    ST_BRANCH
  } state_e;

  typedef enum logic [1:0] {
    SRCB_REG  = 2'b00,
    SRCB_TWO  = 2'b01,
    SRCB_IMM8 = 2'b10,
    SRCB_IMM6 = 2'b11
  } srcb_e;

  typedef struct packed {
    logic             ir_wr;
    logic             pc_wr;
    logic             imem_rd;
    logic             dmem_rd;
    logic             dmem_wr;
    logic             reg_wr;
    logic             mem_to_reg;
    logic             reg_dst;
    logic             alu_src_a;
    srcb_e            alu_src_b;
    logic [ALU_W-1:0] alu_ctrl;
    logic [SH_W-1:0]  shu_ctrl;
    logic             imm_sel;
    logic             flag_wr;
  } ctrl_t;
endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  state_e           state_i,
  input  logic [CLS_W-1:0] op_class_i,
  output state_e           next_o
);
  always_comb begin
    next_o = ST_FETCH;
    unique case (state_i)
      ST_FETCH:  next_o = ST_DECODE;
      ST_DECODE: begin
        if (op_class_i == CLS_AL)                              next_o = ST_EXEWB;
        else if (op_class_i == CLS_LD || op_class_i == CLS_ST) next_o = ST_ADDR;
        else if (op_class_i == CLS_BR)                         next_o = ST_BRANCH;
        else                                                   next_o = ST_FETCH;
      end
      ST_ADDR: begin
        if (op_class_i == CLS_ST)      next_o = ST_SMEM;
        else if (op_class_i == CLS_LD) next_o = ST_RMEM;
        else                           next_o = ST_FETCH;
      end
      ST_RMEM:   next_o = ST_WB;
      default:   next_o = ST_FETCH;  // exewb, smem, wb, branch
    endcase
  end

  AST_FETCH_TO_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FETCH |-> next_o == ST_DECODE);  // R2
  AST_BAD_CLASS_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DECODE && op_class_i[CLS_W-1]) |-> next_o == ST_FETCH);  // R9
endmodule

// File: rtl/mc_ctrl_out.sv
module mc_ctrl_out
  import mc_ctrl_pkg::*;
(
  input  state_e           state_i,
  input  logic [ALU_W-1:0] func_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             cond_i,
  output ctrl_t            ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.ir_wr     = 1'b1;
        ctrl_o.pc_wr     = 1'b1;
        ctrl_o.imem_rd   = 1'b1;
        ctrl_o.alu_src_a = 1'b0;
        ctrl_o.alu_src_b = SRCB_TWO;
        ctrl_o.alu_ctrl  = ALU_ADD;
        ctrl_o.shu_ctrl  = SHU_PASS;
      end
      ST_DECODE: ;
      ST_EXEWB: begin
        ctrl_o.reg_wr     = 1'b1;
        ctrl_o.flag_wr    = 1'b1;
        ctrl_o.mem_to_reg = 1'b0;
        ctrl_o.reg_dst    = 1'b0;
        ctrl_o.alu_src_a  = 1'b1;
        ctrl_o.alu_src_b  = SRCB_REG;
        ctrl_o.alu_ctrl   = func_i;
        ctrl_o.shu_ctrl   = sh_i;
      end
      ST_ADDR: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = SRCB_IMM8;
        ctrl_o.alu_ctrl  = ALU_ADD;
        ctrl_o.shu_ctrl  = SHU_PASS;
        ctrl_o.imm_sel   = 1'b0;
      end
      ST_SMEM: ctrl_o.dmem_wr = 1'b1;
      ST_RMEM: ctrl_o.dmem_rd = 1'b1;
      ST_WB: begin
        ctrl_o.reg_wr     = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
        ctrl_o.reg_dst    = 1'b1;
      end
      ST_BRANCH: begin
        ctrl_o.alu_src_a = 1'b0;
        ctrl_o.alu_src_b = SRCB_IMM6;
        ctrl_o.alu_ctrl  = ALU_ADD;
        ctrl_o.shu_ctrl  = SHU_PASS;
        ctrl_o.imm_sel   = 1'b1;
        ctrl_o.pc_wr     = cond_i;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CLS_W-1:0] op_class_i,
  input  logic [ALU_W-1:0] func_i,
  input  logic [SH_W-1:0]  sh_i,
  input  logic             cond_i,
  output logic             ir_wr_o,
  output logic             pc_wr_o,
  output logic             imem_rd_o,
  output logic             dmem_rd_o,
  output logic             dmem_wr_o,
  output logic             reg_wr_o,
  output logic             mem_to_reg_o,
  output logic             reg_dst_o,
  output logic             alu_src_a_o,
  output logic [1:0]       alu_src_b_o,
  output logic [ALU_W-1:0] alu_ctrl_o,
  output logic [SH_W-1:0]  shu_ctrl_o,
  output logic             imm_sel_o,
  output logic             flag_wr_o
);
  state_e state_q, state_d;
  ctrl_t  ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  mc_ctrl_next u_next (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state_q),
    .op_class_i (op_class_i),
    .next_o     (state_d)
  );

  mc_ctrl_out u_out (
    .state_i (state_q),
    .func_i  (func_i),
    .sh_i    (sh_i),
    .cond_i  (cond_i),
    .ctrl_o  (ctrl)
  );

  assign ir_wr_o      = ctrl.ir_wr;
  assign pc_wr_o      = ctrl.pc_wr;
  assign imem_rd_o    = ctrl.imem_rd;
  assign dmem_rd_o    = ctrl.dmem_rd;
  assign dmem_wr_o    = ctrl.dmem_wr;
  assign reg_wr_o     = ctrl.reg_wr;
  assign mem_to_reg_o = ctrl.mem_to_reg;
  assign reg_dst_o    = ctrl.reg_dst;
  assign alu_src_a_o  = ctrl.alu_src_a;
  assign alu_src_b_o  = ctrl.alu_src_b;
  assign alu_ctrl_o   = ctrl.alu_ctrl;
  assign shu_ctrl_o   = ctrl.shu_ctrl;
  assign imm_sel_o    = ctrl.imm_sel;
  assign flag_wr_o    = ctrl.flag_wr;

  AST_ONE_MEM_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({imem_rd_o, dmem_rd_o, dmem_wr_o}));  // R10
  AST_FETCH_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_wr_o |=> !(ir_wr_o || pc_wr_o || reg_wr_o || dmem_wr_o || dmem_rd_o));  // R3
  AST_READ_THEN_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_rd_o |=> (reg_wr_o && mem_to_reg_o && reg_dst_o));  // R6
  AST_STORE_RETURNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmem_wr_o || reg_wr_o || imm_sel_o) |=> ir_wr_o);  // R8
  AST_FLAG_WITH_ALU_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_o |-> (reg_wr_o && !mem_to_reg_o));  // R4
  AST_ADDR_TO_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR && op_class_i == CLS_LD) |=> dmem_rd_o);  // R5
endmodule

// File: tb/sim_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module sim_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_class = 3'b000;
  logic [2:0] func = 3'b000;
  logic [1:0] sh = 2'b00;
  logic       cond = 1'b0;
  logic ir_wr, pc_wr, imem_rd, dmem_rd, dmem_wr, reg_wr, m2r, rdst, srca, imm_sel, flag_wr;
  logic [1:0] srcb, shu;
  logic [2:0] aluc;
  logic [17:0] obs;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  mc_ctrl_fsm u0 (
    .clk_i(clk), .rst_ni(rst_n), .op_class_i(op_class), .func_i(func), .sh_i(sh),
    .cond_i(cond), .ir_wr_o(ir_wr), .pc_wr_o(pc_wr), .imem_rd_o(imem_rd),
    .dmem_rd_o(dmem_rd), .dmem_wr_o(dmem_wr), .reg_wr_o(reg_wr), .mem_to_reg_o(m2r),
    .reg_dst_o(rdst), .alu_src_a_o(srca), .alu_src_b_o(srcb), .alu_ctrl_o(aluc),
    .shu_ctrl_o(shu), .imm_sel_o(imm_sel), .flag_wr_o(flag_wr)
  );

  assign obs = {ir_wr, pc_wr, imem_rd, dmem_rd, dmem_wr, reg_wr, m2r, rdst,
                srca, srcb, aluc, shu, imm_sel, flag_wr};

  // bench states: 0 fetch 1 decode 2 exe 3 addr 4 store 5 read 6 wb 7 branch
  function automatic logic [17:0] exp_vec(int st, logic [2:0] f, logic [1:0] s, logic c);
    case (st)
      0: return {1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,3'b010,2'b00,1'b0,1'b0};
      2: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,2'b00,f,s,1'b0,1'b1};
      3: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,3'b010,2'b00,1'b0,1'b0};
      4: return 18'b0_0_0_0_1_0_0_0_0_00_000_00_0_0;
      5: return 18'b0_0_0_1_0_0_0_0_0_00_000_00_0_0;
      6: return 18'b0_0_0_0_0_1_1_1_0_00_000_00_0_0;
      7: return {1'b0,c,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,3'b010,2'b00,1'b1,1'b0};
      default: return '0;
    endcase
  endfunction

  function automatic string tag(int st);
    case (st)
      0: return "R2 R10";
      1: return "R3 R10";
      2: return "R4 R10";
      3: return "R5 R10";
      7: return "R7 R10";
      default: return "R6 R10";
    endcase
  endfunction

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // op3 func3 sh2 cond1
  localparam logic [8:0] VEC [10] = '{
    {3'b000, 3'b101, 2'b11, 1'b0},
    {3'b000, 3'b011, 2'b01, 1'b1},
    {3'b001, 3'b111, 2'b10, 1'b0},
    {3'b010, 3'b001, 2'b11, 1'b1},
    {3'b011, 3'b110, 2'b01, 1'b1},
    {3'b011, 3'b110, 2'b01, 1'b0},
    {3'b100, 3'b000, 2'b00, 1'b1},
    {3'b111, 3'b111, 2'b11, 1'b1},
    {3'b001, 3'b000, 2'b00, 1'b1},
    {3'b010, 3'b100, 2'b10, 1'b0}
  };

  task automatic run_instr(logic [8:0] v, bit first);
    int path[5];
    int n;
    {op_class, func, sh, cond} = v;
    path[0] = 0; path[1] = 1;
    case (v[8:6])
      3'b000:  begin path[2] = 2; n = 3; end
      3'b001:  begin path[2] = 3; path[3] = 5; path[4] = 6; n = 5; end
      3'b010:  begin path[2] = 3; path[3] = 4; n = 4; end
      3'b011:  begin path[2] = 7; n = 3; end
      default: n = 2;  // R9
    endcase
    for (int i = 0; i < n; i++) begin
      string t;
      t = tag(path[i]);
      if (i == 0 && !first) t = {t, " R8"};
      if (n == 2) t = {t, " R9"};
      chk(t, obs, exp_vec(path[i], v[5:3], v[2:1], v[0]));
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", obs, exp_vec(0, 3'b0, 2'b0, 1'b0));
    rst_n = 1'b1;
    chk("R1 after release", obs, exp_vec(0, 3'b0, 2'b0, 1'b0));
    for (int k = 0; k < 10; k++) run_instr(VEC[k], k == 0);
    chk("R8 final fetch", obs, exp_vec(0, 3'b0, 2'b0, 1'b0));

    // branch condition toggled while in branch state
    {op_class, func, sh, cond} = {3'b011, 3'b000, 2'b00, 1'b0};
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R7 cond low", obs, exp_vec(7, 3'b0, 2'b0, 1'b0));
    cond = 1'b1; #1;
    chk("R7 cond high", obs, exp_vec(7, 3'b0, 2'b0, 1'b1));
    @(posedge clk); @(negedge clk);
    chk("R8 after branch", obs, exp_vec(0, 3'b0, 2'b0, 1'b0));

    // reset in the middle of a load
    op_class = 3'b001;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R5 addr before reset", obs, exp_vec(3, 3'b0, 2'b0, 1'b0));
    rst_n = 1'b0; #1;
    chk("R1 async reset", obs, exp_vec(0, 3'b0, 2'b0, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R3 decode after reset", obs, 18'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule